// File: doc/BRIEF.md
# Channel-Interleave Address Bit Swizzler

This block rewrites a linear byte address into the form that a dual-channel interleaved memory controller decodes for tiled surfaces. It folds a mode-dependent set of higher address bits (9, 10, 11 and 17) into bit 6 with XOR. The bits that take part depend on the tiling kind of the access (linear, X-tiled or Y-tiled) and on the memory-channel configuration. Every other address bit passes through untouched.

The configuration side is combinational. It reads either a packed addressing-mode word or a pair of per-channel populated-size fields. From these it resolves one swizzle mode for X tiling and one for Y tiling. The request side takes one access per valid/ready transfer and registers the result one cycle later. The result carries the translated address, the effective tiling kind and stride, and the mode that may be shown to software. That reported mode never mentions bit 17, and it never reports an unresolvable mode.

Top module: `swz_top`

## Requirements
- R1: Mode codes are NONE=0, 9=1, 9_10=2, 9_11=3, 9_10_11=4, 9_17=5, 9_10_17=6, UNKNOWN=7. With cfgSizeStyle=0, the addressing mode is cfgWord[1:0]. Addressing mode 0 (single channel) and mode 1 (asymmetric dual channel) both give NONE on modeX and on modeY.
- R2: In addressing mode 2 (interleaved dual channel) with the XOR-disable flag cfgWord[2]=1, modeX is 9_10 and modeY is 9, whatever cfgWord[3] holds.
- R3: In addressing mode 2 with cfgWord[2]=0 and the bit-17 select cfgWord[3]=0, modeX is 9_10_11 and modeY is 9_11.
- R4: In addressing mode 2 with cfgWord[2]=0 and cfgWord[3]=1, modeX is 9_10_17 and modeY is 9_17.
- R5: With cfgSizeStyle=1, cfgWord is ignored. Equal chanSize0 and chanSize1 give modeX=9_10 and modeY=9. Unequal sizes give NONE for both.
- R6: With cfgSizeStyle=0, the following give UNKNOWN for both modeX and modeY: a cfgWord of all ones, or reserved addressing mode 3.
- R7: An accepted tiled request (inTile 1=X, 2=Y) with a resolved mode other than UNKNOWN yields outAddr equal to inAddr, except that bit 6 becomes the XOR of bit 6 and each address bit the mode lists. The mode used is modeX for X and modeY for Y.
- R8: Tile codes 0 and 3 are linear. A linear request yields outAddr equal to inAddr, outTile=0, outMode=NONE and outStride=0.
- R9: outMode reports 9 in place of 9_17 and 9_10 in place of 9_10_17. Other resolved modes are reported as they are.
- R10: A tiled request whose resolved mode is UNKNOWN is downgraded. It yields outTile=0, outMode=NONE, outStride=0 and an unchanged address.
- R11: A request is accepted on a clock edge where inValid and inReady are both high, and its result appears on the outputs after that edge. inReady is high when outValid is low or outReady is high. While outValid is high and outReady is low, the outputs hold.
- R12: After reset, outValid is low and inReady is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgSizeStyle | input | 1 | 1 selects size-matching configuration, 0 selects the addressing-mode word |
| cfgWord | input | CFG_W | Packed addressing-mode configuration word |
| chanSize0 | input | SIZE_W | Populated size of channel 0 |
| chanSize1 | input | SIZE_W | Populated size of channel 1 |
| modeX | output | 3 | Resolved swizzle mode for X tiling |
| modeY | output | 3 | Resolved swizzle mode for Y tiling |
| inValid | input | 1 | Request valid |
| inReady | output | 1 | Request can be accepted |
| inAddr | input | ADDR_W | Linear byte address |
| inTile | input | 2 | Tiling kind of the access |
| inStride | input | STRIDE_W | Surface stride of the access |
| outValid | output | 1 | Result valid |
| outReady | input | 1 | Result consumed |
| outAddr | output | ADDR_W | Translated address |
| outTile | output | 2 | Effective tiling kind |
| outStride | output | STRIDE_W | Effective stride |
| outMode | output | 3 | Swizzle mode reported to software |

## Verification
The bench uses the default parameters: a 32-bit address, a 16-bit configuration word, 8-bit channel sizes and a 16-bit stride. These widths put bit 17 inside the address, so the bit-17 modes can be observed. They also allow an all-ones word distinct from a plain reserved addressing mode. Test addresses set bits 9, 10, 11 and 17 alone and in combination, so that each XOR source is seen flipping bit 6 both on its own and cancelling another. The handshake test holds outReady low across a second request, so both the hold and the same-edge hand-over are exercised.

// File: rtl/swz_pkg.sv
package swz_pkg;

  typedef enum logic [2:0] {
    SWZ_NONE     = 3'd0,
    SWZ_9        = 3'd1,
    SWZ_9_10     = 3'd2,
    SWZ_9_11     = 3'd3,
    SWZ_9_10_11  = 3'd4,
    SWZ_9_17     = 3'd5,
    SWZ_9_10_17  = 3'd6,
    SWZ_UNKNOWN  = 3'd7
  } swzMode_e;

  typedef enum logic [1:0] {
    TILE_LINEAR = 2'd0,
    TILE_X      = 2'd1,
    TILE_Y      = 2'd2,
    TILE_RSVD   = 2'd3
  } tile_e;

  localparam logic [1:0] AM_SINGLE     = 2'd0;
  localparam logic [1:0] AM_ASYM       = 2'd1;
  localparam logic [1:0] AM_INTERLEAVE = 2'd2;

  localparam int BIT_LOW  = 6;
  localparam int BIT_A    = 9;
  localparam int BIT_B    = 10;
  localparam int BIT_C    = 11;
  localparam int BIT_HIGH = 17;

  // strobes from the control module to the datapath
  typedef struct packed {
    logic     mix9;
    logic     mix10;
    logic     mix11;
    logic     mix17;
    logic     forceLinear;
    swzMode_e shownMode;
  } swzStrobe_t;

endpackage

// File: rtl/swz_mode_ctrl.sv
module swz_mode_ctrl
  import swz_pkg::*;
#(
  parameter int CFG_W  = 16,
  parameter int SIZE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgSizeStyle,
  input  logic [CFG_W-1:0]  cfgWord,
  input  logic [SIZE_W-1:0] chanSize0,
  input  logic [SIZE_W-1:0] chanSize1,
  input  logic [1:0]        reqTile,
  output swzMode_e          modeX,
  output swzMode_e          modeY,
  output swzStrobe_t        strobe
);

  logic [1:0] addrMode;
  logic       xorDisable;
  logic       highSelect;
  logic       wordAllOnes;
  logic       sizesMatch;

  assign addrMode    = cfgWord[1:0];
  assign xorDisable  = cfgWord[2];
  assign highSelect  = cfgWord[3];
  assign wordAllOnes = &cfgWord;
  assign sizesMatch  = (chanSize0 == chanSize1);

  // configuration resolution
  always_comb begin
    modeX = SWZ_UNKNOWN;
    modeY = SWZ_UNKNOWN;
    if (cfgSizeStyle) begin
      if (sizesMatch) begin
        modeX = SWZ_9_10;
        modeY = SWZ_9;
      end else begin
        modeX = SWZ_NONE;
        modeY = SWZ_NONE;
      end
    end else begin
      unique case (addrMode)
        AM_SINGLE, AM_ASYM: begin
          modeX = SWZ_NONE;
          modeY = SWZ_NONE;
        end
        AM_INTERLEAVE: begin
          if (xorDisable) begin
            modeX = SWZ_9_10;
            modeY = SWZ_9;
          end else if (!highSelect) begin
            modeX = SWZ_9_10_11;
            modeY = SWZ_9_11;
          end else begin
            modeX = SWZ_9_10_17;
            modeY = SWZ_9_17;
          end
        end
        default: begin
          modeX = SWZ_UNKNOWN;
          modeY = SWZ_UNKNOWN;
        end
      endcase
      if (wordAllOnes) begin
        modeX = SWZ_UNKNOWN;
        modeY = SWZ_UNKNOWN;
      end
    end
  end

  // per-request selection
  swzMode_e tileMode;
  logic     linearReq;
  logic     unresolved;

  always_comb begin
    unique case (reqTile)
      TILE_X:  tileMode = modeX;
      TILE_Y:  tileMode = modeY;
      default: tileMode = SWZ_NONE;
    endcase
  end

  assign linearReq  = (reqTile != TILE_X) && (reqTile != TILE_Y);
  assign unresolved = !linearReq && (tileMode == SWZ_UNKNOWN);

  always_comb begin
    strobe             = '0;
    strobe.shownMode   = SWZ_NONE;
    strobe.forceLinear = linearReq || unresolved;
    if (!strobe.forceLinear) begin
      unique case (tileMode)
        SWZ_9:       begin strobe.mix9 = 1'b1; end
        SWZ_9_10:    begin strobe.mix9 = 1'b1; strobe.mix10 = 1'b1; end
        SWZ_9_11:    begin strobe.mix9 = 1'b1; strobe.mix11 = 1'b1; end
        SWZ_9_10_11: begin strobe.mix9 = 1'b1; strobe.mix10 = 1'b1; strobe.mix11 = 1'b1; end
        SWZ_9_17:    begin strobe.mix9 = 1'b1; strobe.mix17 = 1'b1; end
        SWZ_9_10_17: begin strobe.mix9 = 1'b1; strobe.mix10 = 1'b1; strobe.mix17 = 1'b1; end
        default:     begin end
      endcase
      unique case (tileMode)
        SWZ_9_17:    strobe.shownMode = SWZ_9;
        SWZ_9_10_17: strobe.shownMode = SWZ_9_10;
        default:     strobe.shownMode = tileMode;
      endcase
    end
  end

  assert_shown_hidden_R9: assert property (@(posedge clk) disable iff (!rstN)
    strobe.shownMode != SWZ_9_17 && strobe.shownMode != SWZ_9_10_17 &&
    strobe.shownMode != SWZ_UNKNOWN)
    else $error("reported mode exposes bit 17 or UNKNOWN");

  assert_linear_clean_R8: assert property (@(posedge clk) disable iff (!rstN)
    (reqTile == TILE_LINEAR || reqTile == TILE_RSVD) |->
      (!strobe.mix9 && !strobe.mix10 && !strobe.mix11 && !strobe.mix17 &&
       strobe.forceLinear && strobe.shownMode == SWZ_NONE))
    else $error("linear request carries swizzle strobes");

  assert_allones_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!cfgSizeStyle && wordAllOnes) |-> (modeX == SWZ_UNKNOWN && modeY == SWZ_UNKNOWN))
    else $error("all-ones word did not resolve to UNKNOWN");

  assert_y_no10_R2: assert property (@(posedge clk) disable iff (!rstN)
    modeY != SWZ_9_10 && modeY != SWZ_9_10_11 && modeY != SWZ_9_10_17)
    else $error("Y mode uses bit 10");

  assert_strobe_xor_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.mix10 || strobe.mix11 || strobe.mix17) |-> strobe.mix9)
    else $error("higher bit mixed without bit 9");

endmodule

// File: rtl/swz_datapath.sv
module swz_datapath
  import swz_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int STRIDE_W = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                inValid,
  output logic                inReady,
  input  logic [ADDR_W-1:0]   inAddr,
  input  logic [1:0]          inTile,
  input  logic [STRIDE_W-1:0] inStride,
  input  swzStrobe_t          strobe,
  output logic                outValid,
  input  logic                outReady,
  output logic [ADDR_W-1:0]   outAddr,
  output logic [1:0]          outTile,
  output logic [STRIDE_W-1:0] outStride,
  output swzMode_e            outMode
);

  localparam logic [ADDR_W-1:0] LOW_MASK = ADDR_W'(1) << BIT_LOW;

  logic              accept;
  logic              mixedBit;
  logic [ADDR_W-1:0] nextAddr;

  assign inReady = !outValid || outReady;
  assign accept  = inValid && inReady;

  assign mixedBit = inAddr[BIT_LOW]
                  ^ (strobe.mix9  & inAddr[BIT_A])
                  ^ (strobe.mix10 & inAddr[BIT_B])
                  ^ (strobe.mix11 & inAddr[BIT_C])
                  ^ (strobe.mix17 & inAddr[BIT_HIGH]);

  always_comb begin
    nextAddr          = inAddr;
    nextAddr[BIT_LOW] = mixedBit;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid  <= 1'b0;
      outAddr   <= '0;
      outTile   <= TILE_LINEAR;
      outStride <= '0;
      outMode   <= SWZ_NONE;
    end else if (accept) begin
      outValid  <= 1'b1;
      outAddr   <= nextAddr;
      outTile   <= strobe.forceLinear ? TILE_LINEAR : inTile;
      outStride <= strobe.forceLinear ? '0 : inStride;
      outMode   <= strobe.shownMode;
    end else if (outReady) begin
      outValid  <= 1'b0;
    end
  end

  assert_passthru_R7: assert property (@(posedge clk) disable iff (!rstN)
    accept |=> ((outAddr & ~LOW_MASK) == ($past(inAddr) & ~LOW_MASK)))
    else $error("address bit other than 6 altered");

  assert_hold_R11: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outAddr) &&
      $stable(outMode) && $stable(outStride) && $stable(outTile)))
    else $error("output changed under back-pressure");

  assert_linear_out_R10: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outTile == TILE_LINEAR) |-> (outStride == '0 && outMode == SWZ_NONE))
    else $error("linear result with stride or mode");

  assert_accept_R11: assert property (@(posedge clk) disable iff (!rstN)
    accept |=> outValid)
    else $error("accepted request not presented");

endmodule

// File: rtl/swz_top.sv
module swz_top
  import swz_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int CFG_W    = 16,
  parameter int SIZE_W   = 8,
  parameter int STRIDE_W = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                cfgSizeStyle,
  input  logic [CFG_W-1:0]    cfgWord,
  input  logic [SIZE_W-1:0]   chanSize0,
  input  logic [SIZE_W-1:0]   chanSize1,
  output logic [2:0]          modeX,
  output logic [2:0]          modeY,
  input  logic                inValid,
  output logic                inReady,
  input  logic [ADDR_W-1:0]   inAddr,
  input  logic [1:0]          inTile,
  input  logic [STRIDE_W-1:0] inStride,
  output logic                outValid,
  input  logic                outReady,
  output logic [ADDR_W-1:0]   outAddr,
  output logic [1:0]          outTile,
  output logic [STRIDE_W-1:0] outStride,
  output logic [2:0]          outMode
);

  swzMode_e   resolvedX;
  swzMode_e   resolvedY;
  swzMode_e   shownOut;
  swzStrobe_t strobe;

  swz_mode_ctrl #(.CFG_W(CFG_W), .SIZE_W(SIZE_W)) i_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .cfgSizeStyle (cfgSizeStyle),
    .cfgWord      (cfgWord),
    .chanSize0    (chanSize0),
    .chanSize1    (chanSize1),
    .reqTile      (inTile),
    .modeX        (resolvedX),
    .modeY        (resolvedY),
    .strobe       (strobe)
  );

  swz_datapath #(.ADDR_W(ADDR_W), .STRIDE_W(STRIDE_W)) i_data (
    .clk       (clk),
    .rstN      (rstN),
    .inValid   (inValid),
    .inReady   (inReady),
    .inAddr    (inAddr),
    .inTile    (inTile),
    .inStride  (inStride),
    .strobe    (strobe),
    .outValid  (outValid),
    .outReady  (outReady),
    .outAddr   (outAddr),
    .outTile   (outTile),
    .outStride (outStride),
    .outMode   (shownOut)
  );

  assign modeX   = resolvedX;
  assign modeY   = resolvedY;
  assign outMode = shownOut;

endmodule

// File: tb/test_swz_top.sv
`timescale 1ns/1ps
module test_swz_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgSizeStyle = 1'b0;
  logic [15:0] cfgWord = '0;
  logic [7:0]  chanSize0 = '0;
  logic [7:0]  chanSize1 = '0;
  logic [2:0]  modeX, modeY;
  logic        inValid = 1'b0;
  logic        inReady;
  logic [31:0] inAddr = '0;
  logic [1:0]  inTile = '0;
  logic [15:0] inStride = '0;
  logic        outValid;
  logic        outReady = 1'b1;
  logic [31:0] outAddr;
  logic [1:0]  outTile;
  logic [15:0] outStride;
  logic [2:0]  outMode;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  swz_top i_swz_top (
    .clk(clk), .rstN(rstN), .cfgSizeStyle(cfgSizeStyle), .cfgWord(cfgWord),
    .chanSize0(chanSize0), .chanSize1(chanSize1), .modeX(modeX), .modeY(modeY),
    .inValid(inValid), .inReady(inReady), .inAddr(inAddr), .inTile(inTile),
    .inStride(inStride), .outValid(outValid), .outReady(outReady),
    .outAddr(outAddr), .outTile(outTile), .outStride(outStride), .outMode(outMode)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // bench model of the address rewrite for a mode code
  function automatic logic [31:0] model(input logic [31:0] a, input logic [2:0] m);
    logic b;
    logic [31:0] r;
    b = a[6];
    if (m >= 3'd1 && m <= 3'd6) b = b ^ a[9];
    if (m == 3'd2 || m == 3'd4 || m == 3'd6) b = b ^ a[10];
    if (m == 3'd3 || m == 3'd4) b = b ^ a[11];
    if (m == 3'd5 || m == 3'd6) b = b ^ a[17];
    r = a;
    r[6] = b;
    return r;
  endfunction

  function automatic logic [2:0] hide(input logic [2:0] m);
    if (m == 3'd5) return 3'd1;
    if (m == 3'd6) return 3'd2;
    return m;
  endfunction

  task automatic setCfg(input logic style, input logic [15:0] w,
                        input logic [7:0] s0, input logic [7:0] s1);
    @(negedge clk);
    cfgSizeStyle = style; cfgWord = w; chanSize0 = s0; chanSize1 = s1;
    #1;
  endtask

  task automatic sendReq(input logic [31:0] a, input logic [1:0] t, input logic [15:0] s);
    @(negedge clk);
    inValid = 1'b1; inAddr = a; inTile = t; inStride = s; outReady = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
  endtask

  task automatic checkModes(input string req, input logic [2:0] ex, input logic [2:0] ey);
    check(modeX == ex, req, modeX, ex);
    check(modeY == ey, req, modeY, ey);
  endtask

  task automatic t_reset;
    check(outValid == 1'b0, "R12", outValid, 0);
    check(inReady == 1'b1, "R12", inReady, 1);
  endtask

  task automatic t_addrModes;
    setCfg(0, 16'h0000, 0, 0); checkModes("R1", 3'd0, 3'd0);
    setCfg(0, 16'h0001, 0, 0); checkModes("R1", 3'd0, 3'd0);
    setCfg(0, 16'h0006, 0, 0); checkModes("R2", 3'd2, 3'd1);
    setCfg(0, 16'h000E, 0, 0); checkModes("R2", 3'd2, 3'd1);
    setCfg(0, 16'h0002, 0, 0); checkModes("R3", 3'd4, 3'd3);
    setCfg(0, 16'h000A, 0, 0); checkModes("R4", 3'd6, 3'd5);
  endtask

  task automatic t_sizeStyle;
    setCfg(1, 16'hFFFF, 8'h40, 8'h40); checkModes("R5", 3'd2, 3'd1);
    setCfg(1, 16'h0002, 8'h40, 8'h20); checkModes("R5", 3'd0, 3'd0);
  endtask

  task automatic t_unknown;
    setCfg(0, 16'hFFFF, 0, 0); checkModes("R6", 3'd7, 3'd7);
    setCfg(0, 16'h0003, 0, 0); checkModes("R6", 3'd7, 3'd7);
  endtask

  task automatic t_translate;
    logic [31:0] addrs [6] = '{32'h0000_0200, 32'h0000_0400, 32'h0000_0800,
                               32'h0002_0000, 32'h0002_0640, 32'h1234_5E7F};
    logic [15:0] cfgs [3] = '{16'h0006, 16'h0002, 16'h000A};
    logic [2:0]  xs [3]   = '{3'd2, 3'd4, 3'd6};
    logic [2:0]  ys [3]   = '{3'd1, 3'd3, 3'd5};
    for (int c = 0; c < 3; c++) begin
      setCfg(0, cfgs[c], 0, 0);
      for (int i = 0; i < 6; i++) begin
        sendReq(addrs[i], 2'd1, 16'h0200);
        check(outValid && outAddr == model(addrs[i], xs[c]), "R7", outAddr, model(addrs[i], xs[c]));
        check(outMode == hide(xs[c]) && outTile == 2'd1 && outStride == 16'h0200,
              "R9", {outTile, outMode}, {2'd1, hide(xs[c])});
        sendReq(addrs[i], 2'd2, 16'h0080);
        check(outValid && outAddr == model(addrs[i], ys[c]), "R7", outAddr, model(addrs[i], ys[c]));
        check(outMode == hide(ys[c]) && outTile == 2'd2, "R9", outMode, hide(ys[c]));
      end
    end
  endtask

  task automatic t_linear;
    setCfg(0, 16'h000A, 0, 0);
    sendReq(32'h0002_0E40, 2'd0, 16'h0400);
    check(outAddr == 32'h0002_0E40 && outTile == 2'd0, "R8", outAddr, 32'h0002_0E40);
    check(outMode == 3'd0 && outStride == 16'd0, "R8", {outMode, outStride}, 0);
    sendReq(32'h0002_0E00, 2'd3, 16'h0400);
    check(outAddr == 32'h0002_0E00 && outTile == 2'd0 && outStride == 0 && outMode == 0,
          "R8", {outTile, outAddr}, 32'h0002_0E00);
  endtask

  task automatic t_downgrade;
    setCfg(0, 16'hFFFF, 0, 0);
    sendReq(32'h0000_0E00, 2'd1, 16'h0200);
    check(outAddr == 32'h0000_0E00, "R10", outAddr, 32'h0000_0E00);
    check(outTile == 2'd0 && outMode == 3'd0 && outStride == 0, "R10",
          {outTile, outMode, outStride}, 0);
    setCfg(0, 16'h0003, 0, 0);
    sendReq(32'h0000_0200, 2'd2, 16'h0080);
    check(outAddr == 32'h0000_0200 && outTile == 2'd0 && outStride == 0, "R10",
          outAddr, 32'h0000_0200);
  endtask

  task automatic t_backpressure;
    logic [31:0] a = 32'h0000_0200;
    logic [31:0] b = 32'h0000_0600;
    setCfg(0, 16'h0006, 0, 0);
    @(negedge clk);
    outReady = 1'b0; inValid = 1'b1; inAddr = a; inTile = 2'd1; inStride = 16'h0200;
    @(negedge clk);
    inAddr = b;
    #1;
    check(inReady == 1'b0, "R11", inReady, 0);
    check(outValid && outAddr == model(a, 3'd2), "R11", outAddr, model(a, 3'd2));
    @(negedge clk);
    check(outValid && outAddr == model(a, 3'd2), "R11", outAddr, model(a, 3'd2));
    outReady = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    check(outValid && outAddr == model(b, 3'd2), "R11", outAddr, model(b, 3'd2));
    @(negedge clk);
    check(outValid == 1'b0, "R11", outValid, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    t_reset();
    rstN = 1'b1;
    t_addrModes();
    t_sizeStyle();
    t_unknown();
    t_translate();
    t_linear();
    t_downgrade();
    t_backpressure();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    #400000;
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule